// File: doc/BRIEF.md
# Interrupt Entry Timing Sequencer

This block decides when a small 8-bit controller core takes an interrupt and counts out the hardware cost of entering it. Interrupt sources set request latches. The core marks the final clock of each instruction with a boundary strobe. A global enable gates acceptance. The latches are examined only on the clock edge that ends an instruction. If any request is pending, the block accepts the lowest-numbered one.

After acceptance, the block runs two fixed phases: a call phase that pushes the return state, then a jump phase into the vector. After these it raises a one-cycle strobe that lets the handler's first instruction begin. The accepted source number is reported. That source's latch is cleared and acknowledged at the end of the call phase. Entry latency is therefore the clocks still left in the running instruction, plus the call length, plus the jump length.

Top module: `intEntrySeq`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `pending`, `busy`, `handlerStart`, `ack` and `vecIdx` are all zero. Requests presented during reset are not latched.
- R2: A high bit of `irqSet` at a clock edge sets the matching latch, which shows on `pending` from the next cycle. It stays set until it is serviced.
- R3: A request is accepted only at an edge where `instrLast` is high, the block is idle, `globalEn` is high and a latch is set. `busy` is high from the next cycle.
- R4: If `globalEn` is low at an edge where `instrLast` is high, no entry starts and every latch keeps its value.
- R5: When several latches are set at the accepting edge, the lowest index wins. Its number appears on `vecIdx` from the first busy cycle and is held until the next acceptance.
- R6: The call phase lasts CALL_CYCLES clocks (default 10). Call the cycle that carries the accepting `instrLast` cycle 0. `ack` is high in cycle CALL_CYCLES. From the next cycle only the accepted latch is cleared, and all other latches are unchanged.
- R7: The jump phase lasts JUMP_CYCLES clocks (default 5). `busy` stays high through cycle CALL_CYCLES+JUMP_CYCLES. In cycle CALL_CYCLES+JUMP_CYCLES+1 (default 16), `handlerStart` is high for exactly one cycle and `busy` is low.
- R8: `instrLast` is ignored during the call phase, the jump phase and the `handlerStart` cycle. New requests during these cycles are latched but not accepted, and `vecIdx` does not change.
- R9: If `irqSet` sets the accepted source's latch on the same edge that clears it, the set wins and the latch stays pending.
- R10: Suppose a request becomes pending in cycle j of a 5-cycle instruction, where cycle 1 is the instruction's first cycle and cycle 5 is its last. Then `handlerStart` arrives (6-j)+15 cycles after cycle j. This spans 16 to 20 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| irqSet | input | NUM_SRC | Per-source request set pulses |
| instrLast | input | 1 | High in the final clock of the current instruction |
| globalEn | input | 1 | Global interrupt enable |
| pending | output | NUM_SRC | Current state of the request latches |
| busy | output | 1 | High through the call and jump phases |
| vecIdx | output | $clog2(NUM_SRC) | Index of the most recently accepted source |
| ack | output | 1 | High in the last call-phase cycle, when the accepted latch is cleared |
| handlerStart | output | 1 | One-cycle strobe: the handler's first instruction may start |

## Verification
The bench builds the block with eight sources, a 10-cycle call phase and a 5-cycle jump phase. With these values, the documented 16-to-20-cycle latency window can be checked exactly for every entry point of a 5-cycle instruction. Eight sources are enough for the priority vectors to cover both end indices and mixed patterns. The counts are short enough that requests and boundary strobes can be injected at chosen points inside each phase, including the clearing edge itself.

// File: rtl/intSeqPkg.sv
package intSeqPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CALL,
    ST_JUMP,
    ST_START
  } seqState_t;

  typedef struct packed {
    logic accept;     // load the winning index, begin the call phase
    logic clearSel;   // clear the accepted latch on this edge
    logic inService;  // call or jump phase running
  } seqCtl_t;

endpackage

// File: rtl/intSeqData.sv
module intSeqData
  import intSeqPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IW      = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqSet,
  input  seqCtl_t            ctl,
  output logic [NUM_SRC-1:0] pending,
  output logic               anyPending,
  output logic [IW-1:0]      vecIdx
);

  logic [NUM_SRC-1:0] pendQ;
  logic [IW-1:0]      vecQ;
  logic [IW-1:0]      winIdx;

  // fixed priority: lowest index wins
  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendQ[i]) winIdx = IW'(i);
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gLatch
    logic clrHit;
    assign clrHit = ctl.clearSel && (vecQ == IW'(g));
    always_ff @(posedge clk) begin
      if (!rstN) pendQ[g] <= 1'b0;
      else       pendQ[g] <= irqSet[g] | (pendQ[g] & ~clrHit);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           vecQ <= '0;
    else if (ctl.accept) vecQ <= winIdx;
  end

  assign pending    = pendQ;
  assign anyPending = |pendQ;
  assign vecIdx     = vecQ;

  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.inService && $past(ctl.inService)) |-> $stable(vecQ)); // R8

  AST_CLEAR_SEL: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.clearSel && !irqSet[vecQ]) |-> !pendQ[$past(vecQ)]); // R6

endmodule

// File: rtl/intSeqCtrl.sv
module intSeqCtrl
  import intSeqPkg::*;
#(
  parameter int CALL_CYCLES = 10,
  parameter int JUMP_CYCLES = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    instrLast,
  input  logic    globalEn,
  input  logic    anyPending,
  output seqCtl_t ctl,
  output logic    busy,
  output logic    ack,
  output logic    handlerStart
);

  localparam int MAXC = (CALL_CYCLES > JUMP_CYCLES) ? CALL_CYCLES : JUMP_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  seqState_t     state;
  logic [CW-1:0] cnt;
  logic          sampleOk;
  logic          callDone;
  logic          jumpDone;

  assign sampleOk = (state == ST_IDLE) && instrLast && globalEn && anyPending;
  assign callDone = (state == ST_CALL) && (cnt == CW'(CALL_CYCLES - 1));
  assign jumpDone = (state == ST_JUMP) && (cnt == CW'(JUMP_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (sampleOk) begin
          state <= ST_CALL;
          cnt   <= '0;
        end
        ST_CALL: if (callDone) begin
          state <= ST_JUMP;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        ST_JUMP: if (jumpDone) begin
          state <= ST_START;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state == ST_CALL) || (state == ST_JUMP);
  assign handlerStart = (state == ST_START);
  assign ack          = callDone;

  assign ctl.accept    = sampleOk;
  assign ctl.clearSel  = callDone;
  assign ctl.inService = busy;

  AST_CALL_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_JUMP) |-> ($past(cnt) == CW'(CALL_CYCLES - 1))); // R6

  AST_START_AFTER_JUMP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(handlerStart) |-> ($past(state) == ST_JUMP && $past(cnt) == CW'(JUMP_CYCLES - 1))); // R7

  AST_GATED_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && instrLast && !globalEn) |=> !busy); // R4

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    handlerStart |=> !handlerStart); // R7

endmodule

// File: rtl/intEntrySeq.sv
module intEntrySeq
  import intSeqPkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int CALL_CYCLES = 10,
  parameter int JUMP_CYCLES = 5,
  localparam int IW         = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqSet,
  input  logic               instrLast,
  input  logic               globalEn,
  output logic [NUM_SRC-1:0] pending,
  output logic               busy,
  output logic [IW-1:0]      vecIdx,
  output logic               ack,
  output logic               handlerStart
);

  seqCtl_t ctl;
  logic    anyPending;

  intSeqCtrl #(
    .CALL_CYCLES(CALL_CYCLES),
    .JUMP_CYCLES(JUMP_CYCLES)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .instrLast   (instrLast),
    .globalEn    (globalEn),
    .anyPending  (anyPending),
    .ctl         (ctl),
    .busy        (busy),
    .ack         (ack),
    .handlerStart(handlerStart)
  );

  intSeqData #(
    .NUM_SRC(NUM_SRC),
    .IW     (IW)
  ) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .irqSet    (irqSet),
    .ctl       (ctl),
    .pending   (pending),
    .anyPending(anyPending),
    .vecIdx    (vecIdx)
  );

endmodule

// File: tb/test_intEntrySeq.sv
module test_intEntrySeq;

  localparam int NSRC = 8;
  localparam int CALLC = 10;
  localparam int JUMPC = 5;

  logic            clk = 1'b0;
  logic            rstN;
  logic [NSRC-1:0] irqSet;
  logic            instrLast;
  logic            globalEn;
  logic [NSRC-1:0] pending;
  logic            busy;
  logic [2:0]      vecIdx;
  logic            ack;
  logic            handlerStart;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  intEntrySeq #(.NUM_SRC(NSRC), .CALL_CYCLES(CALLC), .JUMP_CYCLES(JUMPC)) i_intEntrySeq (
    .clk(clk), .rstN(rstN), .irqSet(irqSet), .instrLast(instrLast), .globalEn(globalEn),
    .pending(pending), .busy(busy), .vecIdx(vecIdx), .ack(ack), .handlerStart(handlerStart)
  );

  always #10 clk = ~clk;

  // {request mask, expected winning index}
  localparam logic [15:0] VECS [6] = '{
    {8'b0000_0001, 8'd0},
    {8'b1000_0000, 8'd7},
    {8'b1010_0100, 8'd2},
    {8'b1111_1111, 8'd0},
    {8'b0110_0000, 8'd5},
    {8'b1000_0010, 8'd1}
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; irqSet = '0; instrLast = 1'b0; globalEn = 1'b0;
    tick(); tick();
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R1: reset state, requests during reset ignored
    rstN = 1'b0; irqSet = 8'hFF; instrLast = 1'b1; globalEn = 1'b1;
    tick(); tick();
    chk("R1 pending in reset", pending, 0);
    chk("R1 busy in reset", busy, 0);
    irqSet = '0; instrLast = 1'b0; globalEn = 1'b0;
    rstN = 1'b1;
    tick();
    chk("R1 pending after reset", pending, 0);
    chk("R1 busy", busy, 0);
    chk("R1 handlerStart", handlerStart, 0);
    chk("R1 ack", ack, 0);
    chk("R1 vecIdx", vecIdx, 0);

    // table walk: priority, call/jump timing, selective clear
    foreach (VECS[v]) begin
      logic [7:0] mask;
      logic [2:0] win;
      mask = VECS[v][15:8];
      win  = VECS[v][2:0];
      doReset();
      irqSet = mask;
      tick();
      irqSet = '0; instrLast = 1'b1; globalEn = 1'b1;   // cycle 0
      chk("R2 latched", pending, mask);
      chk("R3 idle before accept", busy, 0);
      tick();                                            // cycle 1
      instrLast = 1'b0;
      chk("R3 busy after accept", busy, 1);
      chk("R5 vecIdx", vecIdx, win);
      for (int c = 2; c <= 16; c++) begin
        tick();
        if (c == 9)  chk("R6 no early ack", ack, 0);
        if (c == 10) chk("R6 ack", ack, 1);
        if (c == 11) chk("R6 only winner cleared", pending, mask & ~(8'd1 << win));
        if (c == 15) begin
          chk("R7 busy last jump cycle", busy, 1);
          chk("R7 no early start", handlerStart, 0);
        end
        if (c == 16) begin
          chk("R7 handlerStart", handlerStart, 1);
          chk("R7 busy low at start", busy, 0);
        end
      end
      tick();
      chk("R7 start one cycle", handlerStart, 0);
    end

    // R4: global enable low blocks entry
    doReset();
    irqSet = 8'h10;
    tick();
    irqSet = '0; instrLast = 1'b1; globalEn = 1'b0;
    tick();
    instrLast = 1'b0;
    chk("R4 no entry when disabled", busy, 0);
    chk("R4 latch kept", pending, 8'h10);
    globalEn = 1'b1;
    tick();
    chk("R3 no accept without boundary", busy, 0);
    instrLast = 1'b1;
    tick();
    instrLast = 1'b0;
    chk("R3 accepted later", busy, 1);
    chk("R5 vecIdx later", vecIdx, 4);

    // R8, R9: boundary ignored while running, set beats clear
    doReset();
    irqSet = 8'h08;
    tick();
    irqSet = '0; instrLast = 1'b1; globalEn = 1'b1;
    tick();
    for (int c = 1; c <= 18; c++) begin
      irqSet = (c == 3) ? 8'h01 : ((c == 10) ? 8'h08 : 8'h00);
      instrLast = (c == 3 || c == 13 || c == 16 || c == 17);
      if (c == 4) begin
        chk("R8 vecIdx unchanged", vecIdx, 3);
        chk("R8 new request latched", pending, 8'h09);
      end
      if (c == 11) chk("R9 set wins over clear", pending, 8'h09);
      if (c == 16) begin
        chk("R7 handlerStart", handlerStart, 1);
        chk("R8 vecIdx held", vecIdx, 3);
      end
      if (c == 17) chk("R8 boundary in start cycle ignored", busy, 0);
      if (c == 18) begin
        chk("R5 next entry busy", busy, 1);
        chk("R5 lowest wins next", vecIdx, 0);
      end
      tick();
    end

    // R10: latency over a 5-cycle instruction
    for (int j = 1; j <= 5; j++) begin
      int tStart;
      doReset();
      globalEn = 1'b1;
      tStart = -1;
      for (int t = 0; t <= 40; t++) begin
        irqSet = (t == j - 1) ? 8'h04 : 8'h00;
        instrLast = (t == 5);
        if (handlerStart && tStart < 0) tStart = t;
        tick();
      end
      chk("R10 latency", tStart - j, (6 - j) + 15);
    end

    finishRun();
  end

endmodule